// File: doc/BRIEF.md
# Banked CPU Bus Interface Controller

This block sits between an 8-bit-data CPU with a 16-bit address bus and a 24-bit memory system. A fast system clock drives it. It counts system-clock ticks to make the two-phase CPU clock `phi2`: a low phase followed by a high phase, each a fixed number of ticks long. While `phi2` is low the CPU puts its bank byte on the data bus. The block passes that byte through a transparent hold stage and freezes it when `phi2` rises. It joins the bank byte to the 16 address lines to form a 24-bit memory address. That address is valid, and the chip selects decoded from it are settled, before `phi2` rises.

A tristate transceiver joins the CPU data bus to the memory data bus, and the block controls it. On a read, the transceiver drives toward the CPU. Its enable window opens a set number of ticks before `phi2` falls, which covers the CPU's data setup time plus the transceiver's turn-on delay. The window closes a set number of ticks after the fall, which covers the CPU's hold time. The window never opens while the CPU might still be driving the bus: that is, before the CPU has released the bus after the rise, or once the CPU has started driving the next bank byte. On a write, the transceiver drives toward memory, and only during the high phase. A memory address strobe rises a fixed number of ticks after `phi2` rises and stays high until the high phase ends. Every delay is a parameter counted in ticks. The block refuses to elaborate with a configuration that breaks any of these timing rules.

Top module: `bbus_ctrl`

## Requirements
- R1: After reset `phi2` starts low. It then alternates between exactly `PH_LO` ticks low and exactly `PH_HI` ticks high.
- R2: `mem_addr[23:16]` follows `cpu_data` while `phi2` is low. It holds the value sampled at the rising edge of `phi2` for the whole high phase. `mem_addr[15:0]` always equals `cpu_addr`.
- R3: `chip_sel[i]` is decoded from `mem_addr` and is set when `(mem_addr & MASK[i]) == BASE[i]`. When several regions match, the lowest index wins, so at most one select is high. The default regions are: index 0 for addresses 0x00C000 to 0x00CFFF, index 1 for bank 0x00, and index 2 for bank 0xFF. The decode is valid during the low phase, before `phi2` rises.
- R4: `addr_stb` rises exactly `STB_DLY` ticks after `phi2` rises. It stays high until `phi2` falls and is never high while `phi2` is low.
- R5: In a read cycle (`cpu_rw_n` = 1 at the rising edge), `xcvr_to_cpu` = 1. `xcvr_oe` is high for the last `EN_LEAD` ticks of the high phase and for the first `EN_HOLD` ticks of the following low phase.
- R6: The transceiver never drives toward the CPU while the CPU may be driving. This means no enable during the first `CPU_REL` ticks of a high phase, and none from tick `BANK_DLY` of a low phase onward. It also means no enable toward the CPU in a write cycle.
- R7: In a write cycle (`cpu_rw_n` = 0 at the rising edge), `xcvr_to_cpu` = 0. `xcvr_oe` is high for the whole high phase and low for the whole low phase.
- R8: While `rst` is high: `phi2` is low; `xcvr_oe`, `addr_stb` and every `chip_sel` are low; `xcvr_to_cpu` is 0; and the bank latch is cleared, so `mem_addr[23:16]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address lines |
| cpu_data | input | 8 | CPU data bus as seen by the block (bank byte during the low phase) |
| cpu_rw_n | input | 1 | 1 = read, 0 = write; sampled at the end of the low phase |
| phi2 | output | 1 | Generated CPU clock |
| mem_addr | output | 24 | Full memory address {bank, cpu_addr} |
| addr_stb | output | 1 | Memory address strobe |
| chip_sel | output | 3 | Priority-decoded region selects |
| xcvr_oe | output | 1 | Transceiver output enable |
| xcvr_to_cpu | output | 1 | Transceiver direction: 1 = memory to CPU, 0 = CPU to memory |

## Verification
The assertions assume that the CPU drives its side of the bus only within the windows set by `CPU_REL` and `BANK_DLY`. They also assume that the address lines, the bank byte and `cpu_rw_n` are stable from the bank-drive point until `phi2` rises. The stimulus drives each cycle's address, bank and direction at tick `BANK_DLY` of the low phase and leaves them alone until the following high phase. It changes `cpu_data` to a different value at the start of the high phase, so a bank latch that leaked through would be seen. At every tick, the bench checks the observed transceiver enable against its own model of when the CPU is driving.

// File: rtl/bbus_pkg.sv
package bbus_pkg;

   localparam int unsigned TICK_W = 8;

   typedef logic [TICK_W-1:0] tick_t;

   // Transceiver direction encoding, also the captured cycle type
   typedef enum logic {
      DIR_TO_MEM = 1'b0,
      DIR_TO_CPU = 1'b1
   } xdir_e;

   function automatic bit fits_tick(input int unsigned v);
      return v <= (1 << TICK_W);
   endfunction

endpackage

// File: rtl/bbus_phase_gen.sv
module bbus_phase_gen
   import bbus_pkg::*;
#(
   parameter int unsigned PH_HI = 8,
   parameter int unsigned PH_LO = 8
) (
   input  logic  clk,
   input  logic  rst,
   output logic  phi2,
   output tick_t tick,
   output logic  lo_last
);

   localparam tick_t HI_END = tick_t'(PH_HI - 1);
   localparam tick_t LO_END = tick_t'(PH_LO - 1);

   logic at_end;

   assign at_end = (tick == (phi2 ? HI_END : LO_END));

   always_ff @(posedge clk) begin
      if (rst) begin
         phi2 <= 1'b0;
         tick <= '0;
      end else if (at_end) begin
         phi2 <= ~phi2;
         tick <= '0;
      end else begin
         tick <= tick + 1'b1;
      end
   end

   // last tick of the low phase: rising edge of phi2 follows
   assign lo_last = !phi2 && at_end;

endmodule

// File: rtl/bbus_bank_latch.sv
module bbus_bank_latch #(
   parameter  int unsigned BANK_W = 8,
   parameter  int unsigned ADDR_W = 16,
   localparam int unsigned MA_W   = BANK_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              phi2,
   input  logic [BANK_W-1:0] cpu_data,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic [MA_W-1:0]   mem_addr
);

   logic [BANK_W-1:0] bank_q;
   logic              open_w;

   assign open_w = !phi2 && !rst;

   // last sample taken is the edge on which phi2 rises
   always_ff @(posedge clk) begin
      if (rst) begin
         bank_q <= '0;
      end else if (!phi2) begin
         bank_q <= cpu_data;
      end
   end

   assign mem_addr = {(open_w ? cpu_data : bank_q), cpu_addr};

endmodule

// File: rtl/bbus_cs_decode.sv
module bbus_cs_decode #(
   parameter int unsigned                AW       = 24,
   parameter int unsigned                NCS      = 3,
   parameter bit                         PRIORITY = 1'b1,
   parameter logic [NCS-1:0][AW-1:0]     BASE     = '0,
   parameter logic [NCS-1:0][AW-1:0]     MASK     = '0
) (
   input  logic           en,
   input  logic [AW-1:0]  addr,
   output logic [NCS-1:0] sel
);

   logic [NCS-1:0] hit;

   for (genvar i = 0; i < NCS; i++) begin : g_match
      assign hit[i] = ((addr & MASK[i]) == BASE[i]);
   end

   if (PRIORITY) begin : g_prio
      logic [NCS-1:0] win;
      always_comb begin
         win = '0;
         for (int i = NCS - 1; i >= 0; i--) begin
            if (hit[i]) begin
               win    = '0;
               win[i] = 1'b1;
            end
         end
      end
      assign sel = en ? win : '0;
   end else begin : g_flat
      assign sel = en ? hit : '0;
   end

endmodule

// File: rtl/bbus_xcvr_ctrl.sv
module bbus_xcvr_ctrl
   import bbus_pkg::*;
#(
   parameter int unsigned PH_HI   = 8,
   parameter int unsigned STB_DLY = 2,
   parameter int unsigned EN_LEAD = 3,
   parameter int unsigned EN_HOLD = 2
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  phi2,
   input  tick_t tick,
   input  logic  lo_last,
   input  logic  cpu_rw_n,
   output logic  addr_stb,
   output logic  xcvr_oe,
   output logic  xcvr_to_cpu
);

   localparam tick_t RD_OPEN = tick_t'(PH_HI - EN_LEAD);
   localparam tick_t RD_SHUT = tick_t'(EN_HOLD);
   localparam tick_t STB_AT  = tick_t'(STB_DLY);

   xdir_e dir_q;
   logic  hi_win;
   logic  lo_win;

   // cycle type frozen on the rising edge; held through the next hold window
   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q <= DIR_TO_MEM;
      end else if (lo_last) begin
         dir_q <= cpu_rw_n ? DIR_TO_CPU : DIR_TO_MEM;
      end
   end

   always_comb begin
      if (dir_q == DIR_TO_CPU) begin
         hi_win = (tick >= RD_OPEN);
         lo_win = (tick < RD_SHUT);
      end else begin
         hi_win = 1'b1;
         lo_win = 1'b0;
      end
   end

   assign xcvr_oe     = !rst && (phi2 ? hi_win : lo_win);
   assign xcvr_to_cpu = (dir_q == DIR_TO_CPU);
   assign addr_stb    = !rst && phi2 && (tick >= STB_AT);

endmodule

// File: rtl/bbus_ctrl.sv
module bbus_ctrl
   import bbus_pkg::*;
#(
   parameter  int unsigned PH_HI       = 8,
   parameter  int unsigned PH_LO       = 8,
   parameter  int unsigned STB_DLY     = 2,
   parameter  int unsigned EN_LEAD     = 3,
   parameter  int unsigned EN_HOLD     = 2,
   parameter  int unsigned CPU_REL     = 3,
   parameter  int unsigned BANK_DLY    = 3,
   parameter  int unsigned BANK_W      = 8,
   parameter  int unsigned ADDR_W      = 16,
   parameter  int unsigned NCS         = 3,
   parameter  bit          CS_PRIORITY = 1'b1,
   localparam int unsigned MA_W        = BANK_W + ADDR_W,
   parameter  logic [NCS-1:0][MA_W-1:0] CS_BASE =
      {24'hFF0000, 24'h000000, 24'h00C000},
   parameter  logic [NCS-1:0][MA_W-1:0] CS_MASK =
      {24'hFF0000, 24'hFF0000, 24'hFFF000}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [BANK_W-1:0] cpu_data,
   input  logic              cpu_rw_n,
   output logic              phi2,
   output logic [MA_W-1:0]   mem_addr,
   output logic              addr_stb,
   output logic [NCS-1:0]    chip_sel,
   output logic              xcvr_oe,
   output logic              xcvr_to_cpu
);

   // elaboration-time configuration checks
   if (PH_HI < 2 || PH_LO < 2 || !fits_tick(PH_HI) || !fits_tick(PH_LO)) begin : g_bad_len
      $error("bbus_ctrl: phase lengths must be 2..2**TICK_W ticks");
   end
   if (EN_LEAD == 0 || EN_LEAD > PH_HI) begin : g_bad_lead
      $error("bbus_ctrl: enable lead must be 1..PH_HI ticks");
   end
   if (EN_LEAD > PH_HI - CPU_REL) begin : g_bad_rel
      $error("bbus_ctrl: enable lead overlaps the CPU bus release time");
   end
   if (EN_HOLD >= BANK_DLY || EN_HOLD >= PH_LO) begin : g_bad_hold
      $error("bbus_ctrl: enable hold overlaps the CPU bank-byte drive");
   end
   if (STB_DLY == 0 || STB_DLY >= PH_HI) begin : g_bad_stb
      $error("bbus_ctrl: strobe delay must fall inside the high phase");
   end
   if (BANK_DLY >= PH_LO) begin : g_bad_bank
      $error("bbus_ctrl: bank byte must appear before phi2 rises");
   end

   tick_t tick;
   logic  lo_last;

   bbus_phase_gen #(
      .PH_HI (PH_HI),
      .PH_LO (PH_LO)
   ) u_phase (
      .clk     (clk),
      .rst     (rst),
      .phi2    (phi2),
      .tick    (tick),
      .lo_last (lo_last)
   );

   bbus_bank_latch #(
      .BANK_W (BANK_W),
      .ADDR_W (ADDR_W)
   ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .phi2     (phi2),
      .cpu_data (cpu_data),
      .cpu_addr (cpu_addr),
      .mem_addr (mem_addr)
   );

   bbus_cs_decode #(
      .AW       (MA_W),
      .NCS      (NCS),
      .PRIORITY (CS_PRIORITY),
      .BASE     (CS_BASE),
      .MASK     (CS_MASK)
   ) u_cs (
      .en   (!rst),
      .addr (mem_addr),
      .sel  (chip_sel)
   );

   bbus_xcvr_ctrl #(
      .PH_HI   (PH_HI),
      .STB_DLY (STB_DLY),
      .EN_LEAD (EN_LEAD),
      .EN_HOLD (EN_HOLD)
   ) u_xcvr (
      .clk         (clk),
      .rst         (rst),
      .phi2        (phi2),
      .tick        (tick),
      .lo_last     (lo_last),
      .cpu_rw_n    (cpu_rw_n),
      .addr_stb    (addr_stb),
      .xcvr_oe     (xcvr_oe),
      .xcvr_to_cpu (xcvr_to_cpu)
   );

endmodule

// File: rtl/bbus_ctrl_chk.sv
module bbus_ctrl_chk #(
   parameter int unsigned PH_HI       = 8,
   parameter int unsigned PH_LO       = 8,
   parameter int unsigned STB_DLY     = 2,
   parameter int unsigned EN_LEAD     = 3,
   parameter int unsigned EN_HOLD     = 2,
   parameter int unsigned CPU_REL     = 3,
   parameter int unsigned BANK_DLY    = 3,
   parameter int unsigned BANK_W      = 8,
   parameter int unsigned MA_W        = 24,
   parameter int unsigned NCS         = 3,
   parameter bit          CS_PRIORITY = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic            phi2,
   input logic [MA_W-1:0] mem_addr,
   input logic            addr_stb,
   input logic [NCS-1:0]  chip_sel,
   input logic            xcvr_oe,
   input logic            xcvr_to_cpu
);

   localparam logic [15:0] HI_N   = 16'(PH_HI);
   localparam logic [15:0] LO_N   = 16'(PH_LO);
   localparam logic [15:0] STB_N  = 16'(STB_DLY);
   localparam logic [15:0] OPEN_N = 16'(PH_HI - EN_LEAD);
   localparam logic [15:0] HOLD_N = 16'(EN_HOLD);
   localparam logic [15:0] REL_N  = 16'(CPU_REL);
   localparam logic [15:0] BDLY_N = 16'(BANK_DLY);

   // sampled run lengths of the current phase
   logic [15:0] hi_run;
   logic [15:0] lo_run;
   logic        seen_fall;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_run    <= '0;
         lo_run    <= '0;
         seen_fall <= 1'b0;
      end else begin
         hi_run <= phi2 ? hi_run + 16'd1 : 16'd0;
         lo_run <= phi2 ? 16'd0 : lo_run + 16'd1;
         if (phi2) seen_fall <= 1'b1;
      end
   end

   AST_PHI_HI_LEN: assert property (@(posedge clk) disable iff (rst)
      $fell(phi2) |-> hi_run == HI_N);                              // R1
   AST_PHI_LO_LEN: assert property (@(posedge clk) disable iff (rst)
      $rose(phi2) && seen_fall |-> lo_run == LO_N);                 // R1
   AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (rst)
      phi2 && $past(phi2) |-> $stable(mem_addr[MA_W-1 -: BANK_W])); // R2
   if (CS_PRIORITY) begin : g_cs_chk
      AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
         $onehot0(chip_sel));                                       // R3
   end
   AST_STB_DELAY: assert property (@(posedge clk) disable iff (rst)
      $rose(addr_stb) |-> phi2 && hi_run == STB_N);                 // R4
   AST_STB_PHASE: assert property (@(posedge clk) disable iff (rst)
      addr_stb |-> phi2);                                           // R4
   AST_RD_LEAD: assert property (@(posedge clk) disable iff (rst)
      xcvr_oe && xcvr_to_cpu && phi2 |-> hi_run >= OPEN_N);         // R5
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
      xcvr_oe && !phi2 |-> xcvr_to_cpu && lo_run < HOLD_N);         // R5
   AST_NO_CLASH_HI: assert property (@(posedge clk) disable iff (rst)
      xcvr_oe && xcvr_to_cpu && phi2 |-> hi_run >= REL_N);          // R6
   AST_NO_CLASH_LO: assert property (@(posedge clk) disable iff (rst)
      xcvr_oe && xcvr_to_cpu && !phi2 |-> lo_run < BDLY_N);         // R6
   AST_WR_WINDOW: assert property (@(posedge clk) disable iff (rst)
      xcvr_oe && !xcvr_to_cpu |-> phi2);                            // R7
   AST_RST_QUIET: assert property (@(posedge clk)
      rst |-> !xcvr_oe && !addr_stb && chip_sel == '0);             // R8
   AST_RST_PHI: assert property (@(posedge clk)
      rst |=> !phi2);                                               // R8

endmodule

bind bbus_ctrl bbus_ctrl_chk #(
   .PH_HI       (PH_HI),
   .PH_LO       (PH_LO),
   .STB_DLY     (STB_DLY),
   .EN_LEAD     (EN_LEAD),
   .EN_HOLD     (EN_HOLD),
   .CPU_REL     (CPU_REL),
   .BANK_DLY    (BANK_DLY),
   .BANK_W      (BANK_W),
   .MA_W        (MA_W),
   .NCS         (NCS),
   .CS_PRIORITY (CS_PRIORITY)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .phi2        (phi2),
   .mem_addr    (mem_addr),
   .addr_stb    (addr_stb),
   .chip_sel    (chip_sel),
   .xcvr_oe     (xcvr_oe),
   .xcvr_to_cpu (xcvr_to_cpu)
);

// File: tb/bbus_ctrl_tb_top.sv
module bbus_ctrl_tb_top;

   localparam int HI   = 8;
   localparam int LO   = 8;
   localparam int STB  = 2;
   localparam int LEAD = 3;
   localparam int HOLD = 2;
   localparam int REL  = 3;
   localparam int BDLY = 3;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] cpu_addr;
   logic [7:0]  cpu_data;
   logic        cpu_rw_n;
   logic        phi2;
   logic [23:0] mem_addr;
   logic        addr_stb;
   logic [2:0]  chip_sel;
   logic        xcvr_oe;
   logic        xcvr_to_cpu;

   int n_chk  = 0;
   int n_fail = 0;
   bit prev_rd = 1'b0;

   always #4 clk = ~clk;

   bbus_ctrl dut_i (
      .clk         (clk),
      .rst         (rst),
      .cpu_addr    (cpu_addr),
      .cpu_data    (cpu_data),
      .cpu_rw_n    (cpu_rw_n),
      .phi2        (phi2),
      .mem_addr    (mem_addr),
      .addr_stb    (addr_stb),
      .chip_sel    (chip_sel),
      .xcvr_oe     (xcvr_oe),
      .xcvr_to_cpu (xcvr_to_cpu)
   );

   task automatic chk_eq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void report();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endfunction

   // R8: reset state, including a cleared bank latch
   task automatic t_reset();
      rst      = 1'b1;
      cpu_addr = 16'h1234;
      cpu_data = 8'h5A;
      cpu_rw_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk_eq("R8", "phi2 in reset", phi2, 1'b0);
      chk_eq("R8", "oe in reset", xcvr_oe, 1'b0);
      chk_eq("R8", "dir in reset", xcvr_to_cpu, 1'b0);
      chk_eq("R8", "strobe in reset", addr_stb, 1'b0);
      chk_eq("R8", "selects in reset", chip_sel, 3'b000);
      chk_eq("R8", "bank cleared", mem_addr, 24'h001234);
      rst     = 1'b0;
      prev_rd = 1'b0;
   endtask

   // one complete bus cycle, checked tick by tick
   task automatic t_cycle(input logic [7:0] bank, input logic [15:0] addr,
                          input bit rd, input logic [2:0] exp_cs, input string name);
      logic was;
      bit   cpu_drv;
      do begin
         was = phi2;
         @(negedge clk);
      end while (!(was === 1'b1 && phi2 === 1'b0));
      for (int j = 0; j < LO; j++) begin
         if (j > 0) @(negedge clk);
         if (j == BDLY) begin
            cpu_data = bank;
            cpu_addr = addr;
            cpu_rw_n = rd;
         end
         #1;
         chk_eq("R1", {name, " phi2 low"}, phi2, 1'b0);
         chk_eq("R4", {name, " strobe low phase"}, addr_stb, 1'b0);
         chk_eq("R5", {name, " hold enable"}, xcvr_oe, prev_rd && (j < HOLD));
         chk_eq("R7", {name, " dir low phase"}, xcvr_to_cpu, prev_rd);
         cpu_drv = (j >= BDLY);
         chk_eq("R6", {name, " clash low"}, cpu_drv && xcvr_oe && xcvr_to_cpu, 1'b0);
         if (j >= BDLY) begin
            chk_eq("R2", {name, " addr transparent"}, mem_addr, {bank, addr});
            chk_eq("R3", {name, " select early"}, chip_sel, exp_cs);
         end
      end
      for (int k = 0; k < HI; k++) begin
         @(negedge clk);
         if (k == 0) cpu_data = ~bank;
         #1;
         chk_eq("R1", {name, " phi2 high"}, phi2, 1'b1);
         chk_eq("R4", {name, " strobe"}, addr_stb, k >= STB);
         chk_eq(rd ? "R5" : "R7", {name, " enable high"}, xcvr_oe,
                rd ? (k >= HI - LEAD) : 1'b1);
         chk_eq(rd ? "R5" : "R7", {name, " dir high"}, xcvr_to_cpu, rd);
         chk_eq("R2", {name, " bank frozen"}, mem_addr, {bank, addr});
         chk_eq("R3", {name, " select"}, chip_sel, exp_cs);
         cpu_drv = rd ? (k < REL) : 1'b1;
         chk_eq("R6", {name, " clash high"}, cpu_drv && xcvr_oe && xcvr_to_cpu, 1'b0);
      end
      prev_rd = rd;
   endtask

   initial begin
      t_reset();
      t_cycle(8'h00, 16'hC123, 1'b1, 3'b001, "io read prio");
      t_cycle(8'h00, 16'h1234, 1'b0, 3'b010, "ram write after read");
      t_cycle(8'hFF, 16'h8000, 1'b1, 3'b100, "rom read after write");
      t_cycle(8'h00, 16'hCFFF, 1'b1, 3'b001, "read after read");
      t_cycle(8'h00, 16'h7FFF, 1'b0, 3'b010, "ram write");
      t_cycle(8'h12, 16'h0000, 1'b0, 3'b000, "unmapped write");
      t_reset();
      t_cycle(8'hFF, 16'hFFFF, 1'b1, 3'b100, "read after reset");
      t_cycle(8'h01, 16'hC000, 1'b1, 3'b000, "unmapped read");
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      report();
      $finish;
   end

endmodule